// File: doc/BRIEF.md
# Fractional clock divider control register bank

This block holds one 32-bit control word that steers four fractional clock outputs. The word is split into four byte-wide lanes, one per output. Each lane carries a 6-bit divide fraction and a gate bit. A lane's output runs at the parent frequency times 18 divided by its fraction, so a larger fraction gives a slower clock. The gate bit is active high: a 1 stops that output.

Software reaches the word through a small word-addressed bus. A write to the base address replaces the word. Three alias addresses change only the bits that are 1 in the write data: one sets them, one clears them and one inverts them. This lets one driver gate or retune its own lane in a single write, without a read-modify-write that could race with another driver working on a different lane. The block exports each lane's fraction and clock enable, and a per-lane flag that is raised whenever the fraction is outside the legal window.

The block is built around a small access state machine. In `IDLE` it takes no action. `ACCESS_WRITE` applies one of four write operations to the register. `ACCESS_READ` captures the register into the read-data holding register. A read and a write in the same cycle perform both actions, and the read sees the value from before the write. Each cycle starts again in `IDLE`.

Top module: `clkfrac_ctrl_bank`

## Requirements
- R1: After reset every lane byte reads 0x92 (gate 1, fraction 18), so the full word is 0x92929292. All `lane_clk_en` bits are 0, every `lane_frac` field is 18, all `lane_range_err` bits are 0 and `bus_rdata` is 0.
- R2: A write with address bits [3:2] = 0 (byte offset 0x0) replaces the stored bits with the write data. The write takes effect at the next rising clock edge. Address bits [1:0] are ignored.
- R3: A write at offset 0x4 (address bits [3:2] = 1) sets to 1 every stored bit that is 1 in the write data and leaves the other bits unchanged.
- R4: A write at offset 0x8 (address bits [3:2] = 2) clears to 0 every stored bit that is 1 in the write data and leaves the other bits unchanged.
- R5: A write at offset 0xC (address bits [3:2] = 3) inverts every stored bit that is 1 in the write data and leaves the other bits unchanged.
- R6: When `bus_re` is high at a rising edge, `bus_rdata` holds the register value from before that edge, starting in the next cycle. This applies at all four addresses. While `bus_re` is low, `bus_rdata` keeps its value.
- R7: Bit 6 of each lane (bits 6, 14, 22 and 30) is reserved. It always reads 0, and writes to it in any mode have no effect.
- R8: `lane_clk_en[n]` is the inverse of the gate bit at word bit 8n+7.
- R9: `lane_frac[6n+5:6n]` equals word bits [8n+5:8n].
- R10: `lane_range_err[n]` is 1 exactly when lane n's fraction is below 12 or above 35, so 0 and 11 are flagged while 12 and 35 are not.
- R11: In a cycle without a write, the register, `lane_frac` and `lane_clk_en` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Byte offset; bits [3:2] select the write mode |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_re` |
| lane_frac | output | 24 | Four 6-bit fractions, lane n at [6n+5:6n] |
| lane_clk_en | output | 4 | Per-lane clock enable (inverted gate bit) |
| lane_range_err | output | 4 | Per-lane fraction out of the 12..35 window |

## Verification
A wrong lane state shows on the ports in the cycle right after the write that caused it. `lane_frac` and `lane_clk_en` come straight from the lane registers, and any read issued afterwards returns the corrupted byte one cycle later. A wrong write-mode decode is caught on the next edge, because the alias writes have distinct effects. Set can only drop enables, clear can only raise them, and toggle must invert exactly the masked gates. A reserved bit that leaks into storage is caught on the next read.

// File: rtl/clkfrac_pkg.sv
package clkfrac_pkg;

    localparam int FRAC_W = 6;
    localparam int LANE_W = 8;
    localparam int GATE_POS = LANE_W - 1;
    localparam int RSV_POS = FRAC_W;

    // Write mode, chosen by address bits [3:2]
    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_SET   = 2'd1,
        OP_CLEAR = 2'd2,
        OP_FLIP  = 2'd3
    } wr_op_e;

    // Per-cycle bus access state
    typedef enum logic [1:0] {
        IDLE         = 2'd0,
        ACCESS_WRITE = 2'd1,
        ACCESS_READ  = 2'd2,
        ACCESS_BOTH  = 2'd3
    } acc_state_e;

    typedef struct packed {
        logic              gate;
        logic [FRAC_W-1:0] frac;
    } lane_t;

endpackage

// File: rtl/clkfrac_decode.sv
module clkfrac_decode
    import clkfrac_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    output acc_state_e        acc_state,
    output wr_op_e            wr_op
);

    always_comb begin
        unique case ({bus_re, bus_we})
            2'b00:   acc_state = IDLE;
            2'b01:   acc_state = ACCESS_WRITE;
            2'b10:   acc_state = ACCESS_READ;
            default: acc_state = ACCESS_BOTH;
        endcase
    end

    always_comb begin
        unique case (bus_addr[3:2])
            2'd0:    wr_op = OP_LOAD;
            2'd1:    wr_op = OP_SET;
            2'd2:    wr_op = OP_CLEAR;
            default: wr_op = OP_FLIP;
        endcase
    end

endmodule

// File: rtl/clkfrac_lane.sv
module clkfrac_lane
    import clkfrac_pkg::*;
#(
    parameter int FRAC_MIN   = 12,
    parameter int FRAC_MAX   = 35,
    parameter int RESET_FRAC = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  wr_op_e            wr_op,
    input  logic [LANE_W-1:0] wr_byte,
    output logic [LANE_W-1:0] lane_byte,
    output logic [FRAC_W-1:0] frac,
    output logic              clk_en,
    output logic              range_err
);

    lane_t             lane_q;
    logic [LANE_W-1:0] cur_byte;
    logic [LANE_W-1:0] nxt_byte;

    // Reserved bit is never stored and always reads as zero
    assign cur_byte = {lane_q.gate, 1'b0, lane_q.frac};

    always_comb begin
        unique case (wr_op)
            OP_LOAD:  nxt_byte = wr_byte;
            OP_SET:   nxt_byte = cur_byte | wr_byte;
            OP_CLEAR: nxt_byte = cur_byte & ~wr_byte;
            OP_FLIP:  nxt_byte = cur_byte ^ wr_byte;
            default:  nxt_byte = cur_byte;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q.gate <= 1'b1;
            lane_q.frac <= FRAC_W'(RESET_FRAC);
        end else if (wr_en) begin
            lane_q.gate <= nxt_byte[GATE_POS];
            lane_q.frac <= nxt_byte[FRAC_W-1:0];
        end
    end

    assign lane_byte = cur_byte;
    assign frac      = lane_q.frac;
    assign clk_en    = ~lane_q.gate;
    assign range_err = (lane_q.frac < FRAC_W'(FRAC_MIN)) ||
                       (lane_q.frac > FRAC_W'(FRAC_MAX));

endmodule

// File: rtl/clkfrac_ctrl_bank.sv
module clkfrac_ctrl_bank
    import clkfrac_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int ADDR_W     = 4,
    parameter int FRAC_MIN   = 12,
    parameter int FRAC_MAX   = 35,
    parameter int RESET_FRAC = 18,
    localparam int DATA_W    = LANES * LANE_W,
    localparam int FRACS_W   = LANES * FRAC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_re,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [FRACS_W-1:0] lane_frac,
    output logic [LANES-1:0]   lane_clk_en,
    output logic [LANES-1:0]   lane_range_err
);

    acc_state_e        acc_state;
    wr_op_e            wr_op;
    logic              do_write;
    logic              do_read;
    logic [DATA_W-1:0] word_now;
    logic [DATA_W-1:0] rdata_q;

    clkfrac_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .acc_state (acc_state),
        .wr_op     (wr_op)
    );

    // Output process of the access state machine
    always_comb begin
        do_write = 1'b0;
        do_read  = 1'b0;
        unique case (acc_state)
            IDLE:         ;
            ACCESS_WRITE: do_write = 1'b1;
            ACCESS_READ:  do_read  = 1'b1;
            ACCESS_BOTH: begin
                do_write = 1'b1;
                do_read  = 1'b1;
            end
            default:      ;
        endcase
    end

    for (genvar n = 0; n < LANES; n++) begin : g_lane
        clkfrac_lane #(
            .FRAC_MIN   (FRAC_MIN),
            .FRAC_MAX   (FRAC_MAX),
            .RESET_FRAC (RESET_FRAC)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (do_write),
            .wr_op     (wr_op),
            .wr_byte   (bus_wdata[n*LANE_W +: LANE_W]),
            .lane_byte (word_now[n*LANE_W +: LANE_W]),
            .frac      (lane_frac[n*FRAC_W +: FRAC_W]),
            .clk_en    (lane_clk_en[n]),
            .range_err (lane_range_err[n])
        );
    end

    // Read-data holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (do_read) begin
            rdata_q <= word_now;
        end
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/clkfrac_ctrl_bank_chk.sv
module clkfrac_ctrl_bank_chk #(
    parameter int LANES  = 4,
    parameter int ADDR_W = 4,
    localparam int DATA_W = LANES * 8,
    localparam int FRACS_W = LANES * 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_we,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic               bus_re,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [FRACS_W-1:0] lane_frac,
    input logic [LANES-1:0]   lane_clk_en
);

    logic [LANES-1:0]  wgate;
    logic [DATA_W-1:0] rsv_mask;

    always_comb begin
        rsv_mask = '0;
        for (int n = 0; n < LANES; n++) begin
            wgate[n] = bus_wdata[8*n+7];
            rsv_mask[8*n+6] = 1'b1;
        end
    end

    // R2: direct write sets enables to the inverse of the written gates
    assert_load_gates_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[3:2] == 2'd0) |=> (lane_clk_en == ~$past(wgate)));

    // R3: set alias can only turn enables off where the mask has gates
    assert_set_gates_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[3:2] == 2'd1) |=>
        ((lane_clk_en & $past(wgate)) == '0) &&
        ((lane_clk_en & ~$past(wgate)) == ($past(lane_clk_en) & ~$past(wgate))));

    // R4: clear alias turns masked enables on, leaves others
    assert_clear_gates_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[3:2] == 2'd2) |=>
        ((~lane_clk_en & $past(wgate)) == '0) &&
        ((lane_clk_en & ~$past(wgate)) == ($past(lane_clk_en) & ~$past(wgate))));

    // R5: toggle alias inverts exactly the masked enables
    assert_flip_gates_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[3:2] == 2'd3) |=>
        (lane_clk_en == ($past(lane_clk_en) ^ $past(wgate))));

    // R6: read data holds while no read
    assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata));

    // R7: reserved bits read as zero
    assert_rsv_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re |=> ((bus_rdata & rsv_mask) == '0));

    // R11: no write, no change
    assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(lane_clk_en) && $stable(lane_frac)));

endmodule

bind clkfrac_ctrl_bank clkfrac_ctrl_bank_chk #(
    .LANES  (LANES),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .bus_re      (bus_re),
    .bus_rdata   (bus_rdata),
    .lane_frac   (lane_frac),
    .lane_clk_en (lane_clk_en)
);

// File: tb/clkfrac_ctrl_bank_test.sv
module clkfrac_ctrl_bank_test;

    localparam int LANES = 4;
    localparam logic [31:0] KEEP = 32'hBFBF_BFBF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic [23:0] lane_frac;
    logic [3:0]  lane_clk_en;
    logic [3:0]  lane_range_err;

    int total = 0;
    int bad = 0;
    logic [31:0] model;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;
    logic        done = 1'b0;

    always #2.5 clk = ~clk;

    clkfrac_ctrl_bank uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_addr       (bus_addr),
        .bus_we         (bus_we),
        .bus_wdata      (bus_wdata),
        .bus_re         (bus_re),
        .bus_rdata      (bus_rdata),
        .lane_frac      (lane_frac),
        .lane_clk_en    (lane_clk_en),
        .lane_range_err (lane_range_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare all lane outputs against the model
    task automatic check_lanes(input string req);
        logic [23:0] ef;
        logic [3:0]  ee;
        logic [3:0]  er;
        for (int n = 0; n < LANES; n++) begin
            ef[6*n +: 6] = model[8*n +: 6];
            ee[n] = ~model[8*n+7];
            er[n] = (model[8*n +: 6] < 6'd12) || (model[8*n +: 6] > 6'd35);
        end
        check({req, " R9 frac"}, {8'h0, lane_frac}, {8'h0, ef});
        check({req, " R8 enable"}, {28'h0, lane_clk_en}, {28'h0, ee});
        check({req, " R10 range"}, {28'h0, lane_range_err}, {28'h0, er});
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input string req);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        case (a[3:2])
            2'd0: model = d & KEEP;
            2'd1: model = model | (d & KEEP);
            2'd2: model = model & ~d;
            default: model = model ^ (d & KEEP);
        endcase
        @(negedge clk);
        bus_we = 1'b0;
        check_lanes(req);
    endtask

    // Driver: push expected read value into the scoreboard
    task automatic rd(input logic [3:0] a, input string req);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        exp_q.push_back(model);
        tag_q.push_back(req);
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    // Read and write on the same edge: read returns the old value
    task automatic rdwr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1; bus_we = 1'b1; bus_wdata = d;
        exp_q.push_back(model);
        tag_q.push_back("R6 read-before-write");
        model = d & KEEP;
        @(negedge clk);
        bus_re = 1'b0; bus_we = 1'b0;
        check_lanes("R2 with read");
    endtask

    always @(posedge clk) rd_seen <= bus_re;

    // Monitor: pop expected value as read data appears
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R6 unexpected read actual=%h expected=none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        logic [31:0] held;
        model = 32'h9292_9292;
        repeat (3) @(negedge clk);
        check("R1 rdata after reset", bus_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check_lanes("R1 reset");
        rd(4'h0, "R1 reset word");

        wr(4'h0, 32'hFFFF_FFFF, "R2 all ones");
        rd(4'h0, "R7 reserved ignored on load");
        wr(4'h0, 32'h0023_4C0C, "R2 mixed");
        rd(4'h4, "R7 reserved via set alias read");
        wr(4'h0, 32'h0B24_0C23, "R10 boundaries");
        rd(4'h8, "R6 read at clear alias");

        wr(4'h4, 32'hC000_0080, "R3 set gates");
        rd(4'hC, "R3 read at toggle alias");
        wr(4'h5, 32'h0000_0101, "R2 low address bits ignored, R3 set");
        rd(4'h0, "R3 set frac bits");
        wr(4'h8, 32'h8080_8040, "R4 clear gates");
        rd(4'h0, "R4 clear result");
        wr(4'h8, 32'h0000_3F00, "R4 clear frac to zero");
        rd(4'h0, "R10 zero fraction");
        wr(4'hC, 32'hC181_8181, "R5 toggle");
        rd(4'h0, "R5 toggle result");
        wr(4'hC, 32'h4040_4040, "R7 toggle reserved only");
        rd(4'h0, "R7 reserved toggle ignored");

        rdwr(4'h0, 32'h9212_A392);
        rd(4'h0, "R2 value after read-write");

        held = bus_rdata;
        @(negedge clk);
        bus_addr = 4'h0; bus_we = 1'b1; bus_wdata = 32'h1111_1111;
        model = 32'h1111_1111;
        @(negedge clk);
        bus_we = 1'b0;
        check("R6 rdata holds without read", bus_rdata, held);
        repeat (3) @(negedge clk);
        check_lanes("R11 idle cycles");
        rd(4'h0, "R11 register unchanged");

        repeat (3) @(negedge clk);
        check("R6 scoreboard drained", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule